// File: doc/BRIEF.md
# ADC Conversion Clock Divider and Startup Timer

This block derives the converter's conversion-clock strobe from the peripheral clock. An 8-bit division setting gives the strobe period: one single-cycle strobe every 2·(P+1) peripheral clocks. No second clock domain is created; downstream logic uses the strobe as a clock enable.

When the enable (wake) input rises, the block holds its ready flag low for a startup delay. A 4-bit code selects the delay from a fixed, nonlinear set of sixteen strobe counts. The flag rises once that many strobes have passed, plus the strobe that ends the wait. Dropping enable stops the strobe, clears the startup progress and lowers ready in the same cycle.

Top module: `adc_clk_startup`

## Requirements
- R1: While reset is asserted and right after it, `adc_tick` and `ready` are 0.
- R2: With enable held high and division setting P, `adc_tick` is a one-cycle pulse that repeats every 2·(P+1) clock cycles.
- R3: After enable is first sampled high at a clock edge, the first `adc_tick` is visible after the (2·P+1)-th such edge.
- R4: A new division setting applied while enabled takes effect only after the strobe that ends the period in progress. The period in progress keeps its old length.
- R5: The startup code selects the delay D in strobes. Codes 0..3 give 0, 8, 16, 24. Codes 4..7 give 64, 80, 96, 112. Codes 8..11 give 512, 576, 640, 704. Codes 12..15 give 768, 832, 896, 960.
- R6: `ready` rises at the clock edge that samples the (D+1)-th strobe after enable. With code 0 this is the first strobe.
- R7: When enable goes low, `adc_tick` and `ready` go low in the same cycle. A later enable restarts the divider and the startup count from zero.
- R8: A change of the startup code while enabled has no effect on the startup delay in progress.
- R9: Once `ready` is high, it stays high for as long as enable stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc | input | 8 | Division setting P; strobe period 2·(P+1) |
| startup_code | input | 4 | Startup delay selector |
| enable | input | 1 | Enable / wake request, level sensitive |
| adc_tick | output | 1 | One-cycle conversion clock strobe |
| ready | output | 1 | Converter ready after startup delay |

## Verification
The assertions take the inputs to be synchronous to `clk` and stable around its rising edge, and reset to be applied before any enable. Under these conditions the divider can never exceed its current limit, and the latched division value can only move at a wrap or while disabled. The bench drives every input on the falling edge. It gives each enable a full clock edge with enable low first, so the settings are latched before counting starts, and it changes settings mid-run only at stated points.

// File: rtl/adc_clk_startup.sv
module adc_clk_startup #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] presc,
  input  logic [3:0]    startup_code,
  input  logic          enable,
  output logic          adc_tick,
  output logic          ready
);
  localparam int DW = PW + 1;
  localparam int SW = 10;

  function automatic logic [SW-1:0] delay_of(input logic [3:0] c);
    logic [SW-1:0] i;
    i = SW'(c[1:0]);
    case (c[3:2])
      2'd0:    delay_of = i << 3;
      2'd1:    delay_of = SW'(64) + (i << 4);
      2'd2:    delay_of = SW'(512) + (i << 6);
      default: delay_of = SW'(768) + (i << 6);
    endcase
  endfunction

  logic [PW-1:0] presc_q;
  logic [DW-1:0] div_cnt;
  logic [SW-1:0] target_q;
  logic [SW-1:0] st_cnt;
  logic          ready_q;

  wire [DW-1:0] lim  = {presc_q, 1'b1};
  wire          wrap = (div_cnt == lim);

  assign adc_tick = enable && wrap;
  assign ready    = enable && ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q  <= '0;
      div_cnt  <= '0;
      target_q <= '0;
      st_cnt   <= '0;
      ready_q  <= 1'b0;
    end else if (!enable) begin
      presc_q  <= presc;
      div_cnt  <= '0;
      target_q <= delay_of(startup_code);
      st_cnt   <= '0;
      ready_q  <= 1'b0;
    end else begin
      if (wrap) begin
        div_cnt <= '0;
        presc_q <= presc;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
      if (adc_tick && !ready_q) begin
        if (st_cnt == target_q) ready_q <= 1'b1;
        else                    st_cnt  <= st_cnt + 1'b1;
      end
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_tick |=> !adc_tick); // R2

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= lim); // R2

  AST_PRESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !wrap) |=> $stable(presc_q)); // R4

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(adc_tick)); // R6

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && enable) |=> ready_q); // R9

  AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st_cnt == '0 && !ready_q && div_cnt == '0)); // R7

  AST_TARGET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable(target_q)); // R8
endmodule

// File: tb/adc_clk_startup_tb.sv
module adc_clk_startup_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] presc = '0;
  logic [3:0] startup_code = '0;
  logic enable = 1'b0;
  logic adc_tick, ready;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  adc_clk_startup u_dut (
    .clk(clk), .rst_n(rst_n), .presc(presc), .startup_code(startup_code),
    .enable(enable), .adc_tick(adc_tick), .ready(ready)
  );

  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{0, 0, 0}, '{0, 3, 24}, '{1, 4, 64}, '{2, 7, 112},
    '{0, 8, 512}, '{1, 15, 960}, '{5, 2, 16}, '{255, 1, 8}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  int t1, t2, t3, rn, wide;

  task automatic run(input int p, input int c, input int horizon,
                     input int chg_n, input int chg_p, input int chg_c);
    t1 = 0; t2 = 0; t3 = 0; rn = 0; wide = 0;
    @(negedge clk);
    enable = 1'b0; presc = 8'(p); startup_code = 4'(c);
    @(negedge clk);
    enable = 1'b1;
    for (int n = 1; n <= horizon; n++) begin
      @(negedge clk);
      if (adc_tick) begin
        if (t1 == 0) t1 = n;
        else if (t2 == 0) begin
          t2 = n;
          if (n == t1 + 1) wide = 1;
        end else if (t3 == 0) t3 = n;
      end
      if (ready && rn == 0) rn = n;
      if (n == chg_n) begin
        presc = 8'(chg_p);
        startup_code = 4'(chg_c);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!adc_tick && !ready, "R1 in reset", {adc_tick, ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!adc_tick && !ready, "R1 after reset", {adc_tick, ready}, 0);

    for (int v = 0; v < NV; v++) begin
      int p, c, d, per, first, er, hz;
      p = VEC[v][0]; c = VEC[v][1]; d = VEC[v][2];
      per = 2 * (p + 1);
      first = 2 * p + 1;
      er = first + 1 + d * per;
      hz = (er > first + per) ? er + 2 : first + per + 2;
      run(p, c, hz, -1, 0, 0);
      check(t1 == first, $sformatf("R3 first tick p=%0d", p), t1, first);
      check(t2 == first + per && wide == 0, $sformatf("R2 period p=%0d", p), t2 - t1, per);
      check(rn == er, $sformatf("R5 R6 ready code=%0d", c), rn, er);
    end

    run(3, 0, 20, 9, 0, 0);
    check(t1 == 7, "R4 first tick", t1, 7);
    check(t2 == 15, "R4 old period kept", t2, 15);
    check(t3 == 17, "R4 new period", t3, 17);

    run(0, 1, 22, 3, 0, 0);
    check(rn == 18, "R8 code change ignored", rn, 18);
    check(ready, "R9 ready held", ready, 1);

    #1;
    enable = 1'b0;
    #0.5;
    check(!ready && !adc_tick, "R7 immediate clear", {ready, adc_tick}, 0);
    run(1, 0, 8, -1, 0, 0);
    check(t1 == 3, "R7 restart tick", t1, 3);
    check(rn == 4, "R7 restart ready", rn, 4);

    summary();
  end
endmodule